// File: doc/BRIEF.md
# I2C Register-Read Target with Auto-Increment

This block is a target on a two-wire I2C bus that hands out the contents of a small register file. It oversamples the open-drain clock and data lines with the system clock and never pulls the clock line low. Its only output towards the bus is an enable that pulls the data line low. The register file sits outside the block and is reached through a parallel read port. The block presents an index, and the register file returns the byte stored there in the same cycle.

A controller first sends a write-addressed frame that carries one register index. The block loads that index into its pointer. The controller then issues a repeated START and sends the same bus address with the read bit set. The block returns one byte after another, most significant bit first. After each byte it moves the pointer to the next register, wrapping at the end of the file. It keeps sending for as long as the controller acknowledges. The controller closes the transfer by answering the last byte with a NACK and then sending STOP.

Top module: `i2c_reg_reader`

## Requirements
- R1: After reset, `sda_oe` is low and `rd_addr` is 0.
- R2: A frame whose first seven bits, sent MSB first, equal `TARGET_ADDR` is acknowledged by holding the data line low through the ninth clock. On any other address the block never pulls the data line low until the next START. A read from a non-matching address therefore returns 8'hFF on the bus, and the pointer is left unchanged.
- R3: After a matching address with the eighth bit 0 (write), the next byte is acknowledged and the pointer becomes that byte modulo `NUM_REGS`.
- R4: After a matching address with the eighth bit 1 (read), the block sends the byte at the pointer, bit 7 first, on eight clocks.
- R5: When the controller answers a data byte with ACK (data line low on the ninth clock), the next byte comes from the pointer plus one, wrapping from `NUM_REGS`-1 to 0.
- R6: The pointer moves forward once after every data byte sent, whether that byte is answered by ACK or by NACK. After a NACK the block sends nothing more. `rd_addr` stays one past the last byte sent, so a later read without a pointer write continues from there.
- R7: In a write transfer, bytes after the register index are not acknowledged, and they leave the pointer unchanged.
- R8: A START or STOP seen in the middle of a frame abandons that frame and leaves the pointer as it was. After a START, the next eight bits are treated as a new address.
- R9: `sda_oe` changes only while the clock line is low.
- R10: `sda_oe` is high only while the block is acknowledging or sending a 0 data bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Level of the bus clock line |
| sda_i | input | 1 | Level of the bus data line |
| sda_oe | output | 1 | High to pull the data line low, low to release it |
| rd_addr | output | PTR_W | Register index presented to the register file (the pointer) |
| rd_data | input | 8 | Byte stored at `rd_addr`, returned in the same cycle |

## Verification
The hardest situations to reach from the ports are a frame cut off partway through and a read that wraps past the last register. Both depend on the bus having reached one exact bit position first. The stimulus bit-bangs both bus lines one bit at a time. It issues a START or a STOP after only two or three bits of a register index, then shows through a following read that the pointer is unchanged and that the new address is decoded. Table entries whose pointer values lie near and above `NUM_REGS` drive the pointer across its wrap point. A read that follows straight after an earlier read brings the pointer value left by a NACK out onto the bus.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_REG,
    ST_REG_ACK,
    ST_TX,
    ST_TX_ACK
  } tgt_state_t;

  // next register index, wrapping at the end of the file
  function automatic int unsigned ptr_wrap_inc(int unsigned p, int unsigned n);
    return (p + 1 >= n) ? 32'd0 : p + 1;
  endfunction

  // register index taken from a received byte
  function automatic int unsigned ptr_from_byte(int unsigned b, int unsigned n);
    return b % n;
  endfunction

  // address byte: bits 7..1 are the bus address, bit 0 the direction
  function automatic logic addr_hit(logic [7:0] frame, logic [6:0] own);
    return frame[7:1] == own;
  endfunction

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  localparam int PW = 2 * STAGES;

  logic [PW-1:0] pipe;
  logic [1:0]    cur;
  logic [1:0]    last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= '1;
      last <= 2'b11;
    end else begin
      pipe <= {pipe[PW-3:0], scl_i, sda_i};
      last <= cur;
    end
  end

  assign cur   = pipe[PW-1 -: 2];
  assign scl_s = cur[1];
  assign sda_s = cur[0];

  assign scl_rise = cur[1] & ~last[1];
  assign scl_fall = ~cur[1] & last[1];
  // data edges while the clock stays high
  assign start_ev = cur[1] & last[1] & last[0] & ~cur[0];
  assign stop_ev  = cur[1] & last[1] & ~last[0] & cur[0];

endmodule

// File: rtl/i2c_tgt_ptr.sv
module i2c_tgt_ptr
  import i2c_tgt_pkg::*;
#(
  parameter int NUM_REGS = 12,
  parameter int PTR_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [7:0]       load_byte,
  input  logic             inc,
  output logic [PTR_W-1:0] ptr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (load) begin
      ptr <= PTR_W'(ptr_from_byte(32'(load_byte), NUM_REGS));
    end else if (inc) begin
      ptr <= PTR_W'(ptr_wrap_inc(32'(ptr), NUM_REGS));
    end
  end

endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] OWN_ADDR  = 7'h2A,
  parameter int         BYTE_BITS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda_s,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic       ptr_load,
  output logic [7:0] ptr_byte,
  output logic       ptr_inc,
  output tgt_state_t st
);

  localparam int CNT_W = $clog2(BYTE_BITS + 1);

  logic [7:0]       shreg;
  logic [CNT_W-1:0] bitcnt;
  logic             rw;
  logic             ctl_ack;
  logic             rx_full;
  logic             rx_done;
  logic             tx_last;

  assign rx_full  = (bitcnt == CNT_W'(BYTE_BITS));
  assign rx_done  = scl_fall && rx_full;
  assign tx_last  = (bitcnt == CNT_W'(BYTE_BITS - 1));
  assign ptr_load = (st == ST_REG) && rx_done;
  assign ptr_byte = shreg;
  assign ptr_inc  = (st == ST_TX) && scl_fall && tx_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      shreg   <= '0;
      bitcnt  <= '0;
      rw      <= 1'b0;
      ctl_ack <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (stop_ev) begin
      st     <= ST_IDLE;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (start_ev) begin
      st     <= ST_ADDR;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: ;
        ST_ADDR, ST_REG: begin
          if (scl_rise && !rx_full) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
          end else if (rx_done) begin
            bitcnt <= '0;
            if (st == ST_REG) begin
              st     <= ST_REG_ACK;
              sda_oe <= 1'b1;
            end else if (addr_hit(shreg, OWN_ADDR)) begin
              st     <= ST_ADDR_ACK;
              rw     <= shreg[0];
              sda_oe <= 1'b1;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (rw) begin
              st     <= ST_TX;
              shreg  <= rd_data;
              sda_oe <= ~rd_data[7];
            end else begin
              st     <= ST_REG;
              sda_oe <= 1'b0;
            end
          end
        end
        ST_REG_ACK: begin
          if (scl_fall) begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (tx_last) begin
              st     <= ST_TX_ACK;
              bitcnt <= '0;
              sda_oe <= 1'b0;
            end else begin
              shreg  <= {shreg[6:0], 1'b0};
              sda_oe <= ~shreg[6];
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            ctl_ack <= ~sda_s;
          end else if (scl_fall) begin
            if (ctl_ack) begin
              st     <= ST_TX;
              shreg  <= rd_data;
              sda_oe <= ~rd_data[7];
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/i2c_reg_reader.sv
module i2c_reg_reader
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h2A,
  parameter int         NUM_REGS    = 12,
  parameter int         SYNC_STAGES = 2,
  localparam int        PTR_W       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  output logic [PTR_W-1:0] rd_addr,
  input  logic [7:0]       rd_data
);

  logic       scl_s;
  logic       sda_s;
  logic       scl_rise;
  logic       scl_fall;
  logic       start_ev;
  logic       stop_ev;
  logic       ptr_load;
  logic       ptr_inc;
  logic [7:0] ptr_byte;
  tgt_state_t st_w;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  i2c_tgt_ctrl #(.OWN_ADDR(TARGET_ADDR), .BYTE_BITS(8)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .sda_s    (sda_s),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .rd_data  (rd_data),
    .sda_oe   (sda_oe),
    .ptr_load (ptr_load),
    .ptr_byte (ptr_byte),
    .ptr_inc  (ptr_inc),
    .st       (st_w)
  );

  i2c_tgt_ptr #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ptr_load),
    .load_byte (ptr_byte),
    .inc       (ptr_inc),
    .ptr       (rd_addr)
  );

endmodule

// File: rtl/i2c_reg_reader_chk.sv
module i2c_reg_reader_chk
  import i2c_tgt_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_s,
  input logic             start_ev,
  input logic             stop_ev,
  input logic             ptr_inc,
  input logic             ptr_load,
  input logic             sda_oe,
  input logic [PTR_W-1:0] rd_addr,
  input tgt_state_t       st
);

  // R9
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  // R10
  oe_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (st == ST_ADDR_ACK || st == ST_REG_ACK || st == ST_TX));

  // R8
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev && !stop_ev |=> (st == ST_ADDR && !sda_oe));

  // R8
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (st == ST_IDLE && !sda_oe));

  // R6
  ptr_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_addr) |-> $past(ptr_inc || ptr_load));

  // R2
  idle_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe);

endmodule

bind i2c_reg_reader i2c_reg_reader_chk #(.PTR_W(PTR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_s    (scl_s),
  .start_ev (start_ev),
  .stop_ev  (stop_ev),
  .ptr_inc  (ptr_inc),
  .ptr_load (ptr_load),
  .sda_oe   (sda_oe),
  .rd_addr  (rd_addr),
  .st       (st_w)
);

// File: tb/i2c_reg_reader_test.sv
module i2c_reg_reader_test;

  localparam logic [6:0] ADDR = 7'h2A;
  localparam int         NREG = 12;
  localparam int         PW   = $clog2(NREG);

  // {register index byte, number of bytes to read}
  localparam logic [15:0] VEC [6] = '{
    16'h0001, 16'h0304, 16'h0A04, 16'h1302, 16'hFF03, 16'h0B01
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          scl = 1'b1;
  logic          sda = 1'b1;
  logic          sda_oe;
  logic [PW-1:0] rd_addr;
  logic [7:0]    rd_data;
  wire           sda_line = sda & ~sda_oe;

  int n_chk = 0;
  int n_fail = 0;
  int bad_oe = 0;
  logic oe_q = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [7:0] regval(int i);
    return 8'((i * 59 + 81) & 255);
  endfunction

  assign rd_data = regval(int'(rd_addr));

  i2c_reg_reader uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl),
    .sda_i   (sda_line),
    .sda_oe  (sda_oe),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  // the data enable must only move while the clock line is low
  always @(posedge clk) begin
    if (rst_n && (sda_oe !== oe_q) && scl) bad_oe <= bad_oe + 1;
    oe_q <= sda_oe;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    scl = 1'b0; tick(5);
    sda = 1'b1; tick(10);
    scl = 1'b1; tick(20);
    sda = 1'b0; tick(20);
  endtask

  task automatic bus_stop();
    scl = 1'b0; tick(5);
    sda = 1'b0; tick(15);
    scl = 1'b1; tick(20);
    sda = 1'b1; tick(20);
  endtask

  task automatic send_bit(logic b);
    scl = 1'b0; tick(5);
    sda = b;    tick(15);
    scl = 1'b1; tick(20);
  endtask

  task automatic send_byte(logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    scl = 1'b0; tick(5);
    sda = 1'b1; tick(15);
    scl = 1'b1; tick(10);
    ack = ~sda_line;
    tick(10);
  endtask

  task automatic read_byte(logic give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      scl = 1'b0; tick(5);
      sda = 1'b1; tick(15);
      scl = 1'b1; tick(10);
      b[i] = sda_line;
      tick(10);
    end
    send_bit(~give_ack);
  endtask

  initial begin
    logic       a;
    logic [7:0] b;
    int         p;
    tick(10);
    // R1 reset state
    check("R1", int'(sda_oe), 0);
    check("R1", int'(rd_addr), 0);
    rst_n = 1'b1;
    tick(10);

    // table: pointer write, repeated START, sequential read
    for (int v = 0; v < 6; v++) begin
      int cnt;
      cnt = int'(VEC[v][7:0]);
      p   = int'(VEC[v][15:8]) % NREG;
      bus_start();
      send_byte({ADDR, 1'b0}, a); check("R2", int'(a), 1);
      send_byte(VEC[v][15:8], a); check("R3", int'(a), 1);
      bus_start();
      send_byte({ADDR, 1'b1}, a); check("R2", int'(a), 1);
      for (int k = 0; k < cnt; k++) begin
        read_byte(k != cnt - 1, b);
        if (k == 0) check("R4", int'(b), int'(regval(p)));
        else        check("R5", int'(b), int'(regval((p + k) % NREG)));
      end
      bus_stop();
      check("R6", int'(rd_addr), (p + cnt) % NREG);
    end

    // R6: read with no pointer write continues after the last NACK (pointer 0)
    bus_start();
    send_byte({ADDR, 1'b1}, a); check("R6", int'(a), 1);
    read_byte(1'b1, b); check("R6", int'(b), int'(regval(0)));
    read_byte(1'b0, b); check("R6", int'(b), int'(regval(1)));
    bus_stop();
    check("R6", int'(rd_addr), 2);

    // R7: bytes after the index are not acknowledged and do not move the pointer
    bus_start();
    send_byte({ADDR, 1'b0}, a); check("R7", int'(a), 1);
    send_byte(8'h05, a);        check("R3", int'(a), 1);
    send_byte(8'hA5, a);        check("R7", int'(a), 0);
    bus_stop();
    check("R7", int'(rd_addr), 5);

    // R2: another address is ignored, in both directions
    bus_start();
    send_byte({7'h2B, 1'b0}, a); check("R2", int'(a), 0);
    send_byte(8'h01, a);         check("R2", int'(a), 0);
    bus_start();
    send_byte({7'h2B, 1'b1}, a); check("R2", int'(a), 0);
    read_byte(1'b0, b);          check("R2", int'(b), 8'hFF);
    bus_stop();
    check("R2", int'(rd_addr), 5);

    // R8: STOP in the middle of an index byte
    bus_start();
    send_byte({ADDR, 1'b0}, a); check("R8", int'(a), 1);
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
    bus_stop();
    check("R8", int'(rd_addr), 5);
    bus_start();
    send_byte({ADDR, 1'b1}, a); check("R8", int'(a), 1);
    read_byte(1'b0, b);         check("R8", int'(b), int'(regval(5)));
    bus_stop();

    // R8: repeated START in the middle of an index byte
    bus_start();
    send_byte({ADDR, 1'b0}, a); check("R8", int'(a), 1);
    send_bit(1'b1); send_bit(1'b1);
    bus_start();
    send_byte({ADDR, 1'b1}, a); check("R8", int'(a), 1);
    read_byte(1'b0, b);         check("R8", int'(b), int'(regval(6)));
    bus_stop();
    check("R8", int'(rd_addr), 7);

    // R9 / R10: enable moved only with the clock low
    check("R9", bad_oe, 0);
    check("R10", int'(sda_oe), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule